// File: doc/BRIEF.md
# Converter Serial Output Port

This block is the digital output side of an oversampling analog-to-digital converter. A 20-bit result enters on a parallel bus with a one-cycle load strobe and is stored in an output register. When the host pulls chip select low, the block shifts the stored word out on a serial data pin, most significant bit first, with no framing or padding. An active-low data-ready flag tells the host whether the register holds a word that has not been read yet.

A mode input chooses who drives the serial clock. With the mode input low, the host supplies the clock; the block synchronises it and moves to the next bit on each falling edge. With the mode input high, the block drives the serial clock itself at a quarter of the master clock, high for one master cycle in four. A calibration input held high for long enough clears the port back to its reset state. The port resumes normal operation once that input falls.

The serial data pin and the serial clock pin are three-state pads. Each is represented here by a value output and an enable output. A low data enable stands for a high-impedance data pin.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, data enable is 0, ready_n is 1 and the generated serial clock is 0. The serial clock enable follows the mode input: 1 means the block drives the clock, 0 means the host drives it.
- R2: A load strobe stores the word and drives ready_n high for exactly four master cycles after the loading edge. ready_n is low in the fifth cycle.
- R3: With mode = 0, data enable rises one master cycle after chip select is sampled low, with bit 19 on the data pin. Each synchronised falling edge of the host clock moves to the next lower bit. After the 20th falling edge, data enable drops and ready_n goes high.
- R4: With mode = 1, the block generates exactly 20 clock pulses. Each pulse is one master cycle high, and pulses are four master cycles apart. The data pin holds steady through each high phase. The bits come out most significant first.
- R5: Chip select rising in the middle of a word ends the transfer on the next cycle: data enable and the generated clock drop, and ready_n is unchanged. The next transfer restarts at bit 19 of the current register contents.
- R6: A load during a transfer does not disturb the word being shifted, but it still gives the four-cycle ready_n pulse. ready_n is low again after the old word completes. The next transfer sends the new word.
- R7: Holding the calibration input high for five or more master cycles clears the register and the transfer state and drives ready_n high. Holding it for four cycles has no effect. After the input falls, loads and transfers work normally.
- R8: A transfer starts only on a high-to-low change of chip select. Holding chip select low after a word completes does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_mode | input | 1 | 0: host drives serial clock, 1: block drives it |
| sclk_in | input | 1 | Serial clock from the host |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for the serial clock pad |
| cs_n | input | 1 | Chip select, active low |
| cal | input | 1 | Calibration strobe, active high |
| word_in | input | 20 | Conversion result |
| word_load | input | 1 | Load strobe for word_in |
| sdata_out | output | 1 | Serial data value |
| sdata_oe | output | 1 | Serial data drive enable (0 = high impedance) |
| rdy_n | output | 1 | Data ready, active low |

## Verification
The hardest case to reach is a register load that lands in the middle of a word. To get there, the host must hold the serial clock still part way through a transfer, strobe a new word in, and then check three things: the blanking pulse, the unchanged remainder of the old word, and the state of ready_n once that word ends. The bench drives the host clock by hand in externally clocked mode so that it can stop between bits. It does the same to place a calibration hold, and a chip-select abort, at a known bit. Around these cases, it sweeps walking-one, walking-zero and arithmetic words through both clock modes.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int W        = 20,
  parameter int BLANK    = 4,
  parameter int CAL_HOLD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_mode,
  input  logic         sclk_in,
  output logic         sclk_out,
  output logic         sclk_oe,
  input  logic         cs_n,
  input  logic         cal,
  input  logic [W-1:0] word_in,
  input  logic         word_load,
  output logic         sdata_out,
  output logic         sdata_oe,
  output logic         rdy_n
);
  localparam int CW = $clog2(W);
  localparam int BW = $clog2(BLANK + 1);
  localparam int HW = $clog2(CAL_HOLD + 1);

  logic [2:0]    sync;
  logic          cs_q, busy, valid, newer;
  logic [1:0]    ph;
  logic [CW-1:0] bcnt;
  logic [W-1:0]  out_reg, sh;
  logic [BW-1:0] blank;
  logic [HW-1:0] cal_cnt;

  wire cal_rst   = cal && (cal_cnt == HW'(CAL_HOLD));
  wire host_fall = sync[2] & ~sync[1];
  wire advance   = busy & (clk_mode ? (ph == 2'd2) : host_fall);
  wire last      = advance && (bcnt == CW'(W - 1));
  wire start     = cs_q & ~cs_n & ~busy;
  wire abort     = busy & cs_n;

  assign sdata_oe  = busy;
  assign sdata_out = busy ? sh[W-1] : 1'b0;
  assign sclk_oe   = clk_mode;
  assign sclk_out  = clk_mode & busy & (ph == 2'd2);
  assign rdy_n     = ~valid | (blank != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= '0;
      cs_q    <= 1'b1;
      cal_cnt <= '0;
      busy    <= 1'b0;
      valid   <= 1'b0;
      newer   <= 1'b0;
      ph      <= '0;
      bcnt    <= '0;
      out_reg <= '0;
      sh      <= '0;
      blank   <= '0;
    end else begin
      sync <= {sync[1:0], sclk_in};
      cs_q <= cs_n;
      if (!cal)
        cal_cnt <= '0;
      else if (cal_cnt != HW'(CAL_HOLD))
        cal_cnt <= cal_cnt + 1'b1;

      if (cal_rst) begin
        busy    <= 1'b0;
        valid   <= 1'b0;
        newer   <= 1'b0;
        ph      <= '0;
        bcnt    <= '0;
        out_reg <= '0;
        sh      <= '0;
        blank   <= '0;
      end else begin
        if (blank != '0)
          blank <= blank - 1'b1;

        if (abort) begin
          busy <= 1'b0;
        end else if (start) begin
          busy  <= 1'b1;
          sh    <= out_reg;
          bcnt  <= '0;
          ph    <= '0;
          newer <= word_load;
        end else if (busy) begin
          ph <= ph + 1'b1;
          if (advance) begin
            sh   <= sh << 1;
            bcnt <= bcnt + 1'b1;
            if (last) begin
              busy  <= 1'b0;
              valid <= newer;
            end
          end
        end

        if (word_load) begin
          out_reg <= word_in;
          valid   <= 1'b1;
          blank   <= BW'(BLANK);
          if (busy && !start)
            newer <= 1'b1;
        end
      end
    end
  end
endmodule

module adc_serial_port_props (
  input logic clk,
  input logic rst_n,
  input logic cal_rst,
  input logic busy,
  input logic cs_n,
  input logic word_load,
  input logic sclk_out,
  input logic sdata_out,
  input logic sdata_oe,
  input logic rdy_n
);
  p_blank_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && !cal_rst) |=> rdy_n);

  p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out |=> !sclk_out);

  p_data_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_out |-> $stable(sdata_out));

  p_abort_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n) |=> !sdata_oe);

  p_cal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_rst |=> (rdy_n && !sdata_oe));
endmodule

bind adc_serial_port adc_serial_port_props u_props (
  .clk(clk), .rst_n(rst_n), .cal_rst(cal_rst), .busy(busy), .cs_n(cs_n),
  .word_load(word_load), .sclk_out(sclk_out), .sdata_out(sdata_out),
  .sdata_oe(sdata_oe), .rdy_n(rdy_n)
);

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, clk_mode, sclk_in, cs_n, cal, word_load;
  logic [19:0] word_in;
  logic        sclk_out, sclk_oe, sdata_out, sdata_oe, rdy_n;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .cs_n(cs_n), .cal(cal),
    .word_in(word_in), .word_load(word_load), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .rdy_n(rdy_n)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [19:0] w, input string req);
    word_in = w; word_load = 1'b1;
    nclk(1);
    word_load = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(rdy_n == 1'b1, req, int'(rdy_n), 1);
      nclk(1);
    end
    chk(rdy_n == 1'b0, req, int'(rdy_n), 0);
  endtask

  task automatic ext_bit(output logic b);
    b = sdata_out;
    sclk_in = 1'b1; nclk(3);
    sclk_in = 1'b0; nclk(4);
  endtask

  task automatic read_ext(output logic [19:0] w, input string req);
    logic b;
    w = '0;
    cs_n = 1'b0; nclk(1);
    chk(sdata_oe == 1'b1, req, int'(sdata_oe), 1);
    for (int i = 0; i < 20; i++) begin
      ext_bit(b);
      w = {w[18:0], b};
    end
    chk(sdata_oe == 1'b0, req, int'(sdata_oe), 0);
    nclk(5);
    chk(sdata_oe == 1'b0, "R8", int'(sdata_oe), 0);
    cs_n = 1'b1; nclk(2);
  endtask

  task automatic read_self(output logic [19:0] w, input string req);
    int pulses, lastc, bad;
    logic prev;
    w = '0; pulses = 0; lastc = 0; bad = 0;
    cs_n = 1'b0; nclk(1);
    chk(sdata_oe == 1'b1, req, int'(sdata_oe), 1);
    prev = sdata_out;
    for (int c = 0; c < 120; c++) begin
      if (sclk_out) begin
        if (pulses > 0 && c - lastc != 4) bad++;
        if (sdata_out != prev) bad++;
        w = {w[18:0], sdata_out};
        lastc = c;
        pulses++;
      end
      prev = sdata_out;
      nclk(1);
    end
    chk(pulses == 20, "R4 pulse count", pulses, 20);
    chk(bad == 0, "R4 spacing/steady", bad, 0);
    chk(sdata_oe == 1'b0 && sclk_out == 1'b0, "R8", int'(sdata_oe), 0);
    cs_n = 1'b1; nclk(2);
  endtask

  logic [19:0] got, w, a, bw;
  logic        bit_v;

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; cal = 1'b0; sclk_in = 1'b0;
    word_load = 1'b0; word_in = '0; clk_mode = 1'b0;
    nclk(3);
    rst_n = 1'b1; nclk(1);
    // R1
    chk(sdata_oe == 1'b0, "R1 oe", int'(sdata_oe), 0);
    chk(rdy_n == 1'b1, "R1 rdy_n", int'(rdy_n), 1);
    chk(sclk_out == 1'b0, "R1 sclk", int'(sclk_out), 0);
    chk(sclk_oe == 1'b0, "R1 sclk_oe", int'(sclk_oe), 0);
    clk_mode = 1'b1; nclk(1);
    chk(sclk_oe == 1'b1, "R1 sclk_oe", int'(sclk_oe), 1);

    // R2 R3 R4 sweep
    for (int m = 0; m < 2; m++) begin
      clk_mode = m[0];
      for (int k = 0; k < 48; k++) begin
        if (k < 20) w = 20'(1 << k);
        else if (k < 40) w = ~20'(1 << (k - 20));
        else w = 20'(k * 32'h2D4B7 + 32'h13579);
        load(w, "R2");
        if (m == 0) read_ext(got, "R3"); else read_self(got, "R4");
        chk(got == w, m == 0 ? "R3 word" : "R4 word", int'(got), int'(w));
        chk(rdy_n == 1'b1, "R3 ready after word", int'(rdy_n), 1);
      end
    end

    // R5 abort, self-clocked
    clk_mode = 1'b1; a = 20'hA5C3E;
    load(a, "R2");
    cs_n = 1'b0; nclk(30);
    cs_n = 1'b1; nclk(1);
    chk(sdata_oe == 1'b0, "R5 oe", int'(sdata_oe), 0);
    chk(sclk_out == 1'b0, "R5 sclk", int'(sclk_out), 0);
    chk(rdy_n == 1'b0, "R5 rdy_n", int'(rdy_n), 0);
    nclk(2);
    read_self(got, "R5");
    chk(got == a, "R5 restart", int'(got), int'(a));

    // R5 abort, host-clocked
    clk_mode = 1'b0; a = 20'h3C96F;
    load(a, "R2");
    cs_n = 1'b0; nclk(1);
    for (int i = 0; i < 7; i++) ext_bit(bit_v);
    cs_n = 1'b1; nclk(1);
    chk(sdata_oe == 1'b0, "R5 oe ext", int'(sdata_oe), 0);
    nclk(2);
    read_ext(got, "R5");
    chk(got == a, "R5 restart ext", int'(got), int'(a));

    // R6 load mid-transfer
    a = 20'h81F0D; bw = 20'h5E2B7;
    load(a, "R2");
    got = '0;
    cs_n = 1'b0; nclk(1);
    for (int i = 0; i < 6; i++) begin ext_bit(bit_v); got = {got[18:0], bit_v}; end
    load(bw, "R6 blank");
    for (int i = 0; i < 14; i++) begin ext_bit(bit_v); got = {got[18:0], bit_v}; end
    chk(got == a, "R6 old word", int'(got), int'(a));
    chk(sdata_oe == 1'b0, "R6 oe", int'(sdata_oe), 0);
    chk(rdy_n == 1'b0, "R6 rdy_n", int'(rdy_n), 0);
    cs_n = 1'b1; nclk(2);
    read_ext(got, "R6");
    chk(got == bw, "R6 new word", int'(got), int'(bw));
    chk(rdy_n == 1'b1, "R6 consumed", int'(rdy_n), 1);

    // R7 calibration
    a = 20'h6D1A4;
    load(a, "R2");
    cal = 1'b1; nclk(4); cal = 1'b0; nclk(1);
    chk(rdy_n == 1'b0, "R7 short cal", int'(rdy_n), 0);
    read_ext(got, "R7");
    chk(got == a, "R7 short cal word", int'(got), int'(a));
    load(20'hFFFFF, "R2");
    cal = 1'b1; nclk(6);
    chk(rdy_n == 1'b1, "R7 long cal", int'(rdy_n), 1);
    cal = 1'b0; nclk(2);
    chk(rdy_n == 1'b1, "R7 after cal", int'(rdy_n), 1);
    read_ext(got, "R7");
    chk(got == 20'h0, "R7 cleared", int'(got), 0);
    bw = 20'h2B3C4;
    load(bw, "R7");
    read_ext(got, "R7");
    chk(got == bw, "R7 resumed", int'(got), int'(bw));
    load(20'h12345, "R2");
    cs_n = 1'b0; nclk(1);
    for (int i = 0; i < 3; i++) ext_bit(bit_v);
    cal = 1'b1; nclk(6);
    chk(sdata_oe == 1'b0, "R7 mid-word oe", int'(sdata_oe), 0);
    cal = 1'b0; cs_n = 1'b1; nclk(2);
    chk(rdy_n == 1'b1, "R7 mid-word rdy_n", int'(rdy_n), 1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule